// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a 24-bit down-counting timer that produces a steady periodic event for an operating-system scheduler or any other consumer of a fixed time base. Software programs a reload value, picks a count source and turns the counter on. Each counting event lowers the current value by one. When the value moves from one to zero, the block raises a sticky wrap flag and, if enabled, a one-cycle interrupt request. On the next counting event the counter takes the reload value again, so the period is reload + 1 events.

The count source is either every core clock cycle or a single-cycle reference strobe, `ref_tick`, which is synchronous to the core clock. Four word registers are selected by a two-bit address on a simple single-cycle bus: control/status (0), reload (1), current value (2) and calibration (3). Read data is combinational from the register state. A read of control/status returns the wrap flag and clears it at the next edge. A write of any value to the current-value register zeroes the counter and drops the flag. Calibration content is set by parameters and is read-only.

Top module: `tick_timer`

## Requirements
- R1: After reset, control/status, reload and current value all read 0, the wrap flag is clear and `irq` is low.
- R2: Control/status bit 0 enables counting, bit 1 enables the interrupt and bit 2 selects the source (1 = core clock, 0 = `ref_tick`). These bits are writable and read back. All other control/status bits except bit 16 read 0.
- R3: When enabled with the core-clock source, the counter changes on every clock edge. When disabled, it holds its value.
- R4: When enabled with the reference source, the counter changes only on edges where `ref_tick` is 1.
- R5: On a counting event at 0, the counter loads the reload value. With a reload value of 0, the counter stays at 0 and never wraps.
- R6: A counting event that takes the counter from 1 to 0 sets the wrap flag, which reads at control/status bit 16.
- R7: A read of control/status returns the flag and clears it at the next edge. If a wrap occurs on that same edge, the flag stays set.
- R8: A write to the current-value register, whatever its data, sets the counter to 0 and clears the flag. This write takes priority over a wrap on the same edge, and that wrap raises no interrupt.
- R9: On a wrap with the interrupt enabled, `irq` is high for exactly one cycle, in the cycle where the counter first reads 0. With the interrupt disabled, `irq` stays low.
- R10: Bits 31:24 of reload and current-value writes are ignored, and those bits read back as 0.
- R11: Calibration bits 23:0 hold the 10 ms reload value (default 0x0F4240). Bit 30 is set when that value is imprecise (default set). Bit 31 is set when no reference source exists (default clear). Writes to this register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select: 0 control/status, 1 reload, 2 current, 3 calibration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| ref_tick | input | 1 | Single-cycle reference count strobe |
| irq | output | 1 | One-cycle wrap interrupt request |

## Verification
The embedded properties check on every cycle that the counter steps down by exactly one or holds according to its count qualifier. They also check that `irq` is a single-cycle pulse that coincides with a zero count, that the flag only rises as the count lands on zero, and that a current-value write always leaves the flag clear. Only the bench scenarios can show the register-level behaviour. That covers the exact reload period, counting gated by the reference strobe, and the ordering between a status read or current-value write and a wrap on the same edge. It also covers masking of the upper write bits and the fixed calibration word.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_RELOAD  = 2'd1,
      SEL_CURRENT = 2'd2,
      SEL_CALIB   = 2'd3
   } reg_sel_e;

   localparam int BIT_RUN      = 0;
   localparam int BIT_IRQ_EN   = 1;
   localparam int BIT_SRC_CORE = 2;
   localparam int BIT_WRAPPED  = 16;
   localparam int BIT_IMPRECISE = 30;
   localparam int BIT_NO_REF   = 31;

   typedef struct packed {
      logic src_core;
      logic irq_en;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/tick_timer_src.sv
`timescale 1ns/1ps
module tick_timer_src #(
   parameter int HAS_REF = 1
) (
   input  logic run,
   input  logic src_core,
   input  logic ref_tick,
   output logic tick
);
   generate
      if (HAS_REF != 0) begin : g_sel
         assign tick = run & (src_core | ref_tick);
      end else begin : g_core_only
         logic unused_src;
         assign unused_src = src_core ^ ref_tick;
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/tick_timer_count.sv
`timescale 1ns/1ps
module tick_timer_count #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_now,
   output logic             irq_q
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   assign wrap_now = tick & ~clr & (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
         irq_q <= 1'b0;
      end else begin
         irq_q <= wrap_now & irq_en;
         if (clr)
            cnt_q <= ZERO;
         else if (tick)
            cnt_q <= (cnt_q == ZERO) ? reload : cnt_q - ONE;
      end
   end

   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(cnt_q));

   // R9
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);

   // R9
   irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (cnt_q == ZERO));
endmodule

// File: rtl/tick_timer_regs.sv
`timescale 1ns/1ps
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          CNT_W     = 24,
   parameter int          HAS_REF   = 1,
   parameter logic [31:0] CAL_TENMS = 32'h000F_4240,
   parameter bit          CAL_SKEW  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              wrap_now,
   output ctrl_t             ctrl_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic              cur_clr,
   output logic              flag_q
);
   localparam int PAD_W = DATA_W - CNT_W;

   initial begin : param_chk
      if (DATA_W != 32) $fatal(1, "DATA_W must be 32");
      if (CNT_W < 2 || CNT_W > 30) $fatal(1, "CNT_W out of range");
      if ((CAL_TENMS >> CNT_W) != 0) $fatal(1, "CAL_TENMS wider than counter");
   end

   logic wr_ctrl, wr_reload, rd_stat;
   logic unused_hi;

   assign wr_ctrl   = bus_sel &  bus_wr & (bus_addr == SEL_CTRL);
   assign wr_reload = bus_sel &  bus_wr & (bus_addr == SEL_RELOAD);
   assign cur_clr   = bus_sel &  bus_wr & (bus_addr == SEL_CURRENT);
   assign rd_stat   = bus_sel & ~bus_wr & (bus_addr == SEL_CTRL);
   assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run      <= bus_wdata[BIT_RUN];
            ctrl_q.irq_en   <= bus_wdata[BIT_IRQ_EN];
            ctrl_q.src_core <= bus_wdata[BIT_SRC_CORE];
         end
         if (wr_reload)
            reload_q <= bus_wdata[CNT_W-1:0];
         if (cur_clr)
            flag_q <= 1'b0;
         else if (wrap_now)
            flag_q <= 1'b1;
         else if (rd_stat)
            flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         SEL_CTRL: begin
            bus_rdata[BIT_RUN]      = ctrl_q.run;
            bus_rdata[BIT_IRQ_EN]   = ctrl_q.irq_en;
            bus_rdata[BIT_SRC_CORE] = ctrl_q.src_core;
            bus_rdata[BIT_WRAPPED]  = flag_q;
         end
         SEL_RELOAD:  bus_rdata = {{PAD_W{1'b0}}, reload_q};
         SEL_CURRENT: bus_rdata = {{PAD_W{1'b0}}, cnt};
         default: begin
            bus_rdata[CNT_W-1:0]   = CAL_TENMS[CNT_W-1:0];
            bus_rdata[BIT_IMPRECISE] = CAL_SKEW;
            bus_rdata[BIT_NO_REF]  = (HAS_REF == 0);
         end
      endcase
   end

   // R8
   clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_clr |=> !flag_q);

   // R7
   stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !wrap_now) |=> !flag_q);
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int          CNT_W     = 24,
   parameter int          HAS_REF   = 1,
   parameter logic [31:0] CAL_TENMS = 32'h000F_4240,
   parameter bit          CAL_SKEW  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        ref_tick,
   output logic        irq
);
   localparam int DATA_W = 32;

   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload, cnt;
   logic             tick, cur_clr, wrap_now, flag;

   tick_timer_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .HAS_REF(HAS_REF),
      .CAL_TENMS(CAL_TENMS), .CAL_SKEW(CAL_SKEW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt), .wrap_now(wrap_now),
      .ctrl_q(ctrl), .reload_q(reload), .cur_clr(cur_clr), .flag_q(flag)
   );

   tick_timer_src #(.HAS_REF(HAS_REF)) u_src (
      .run(ctrl.run), .src_core(ctrl.src_core),
      .ref_tick(ref_tick), .tick(tick)
   );

   tick_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cur_clr),
      .irq_en(ctrl.irq_en), .reload(reload),
      .cnt_q(cnt), .wrap_now(wrap_now), .irq_q(irq)
   );

   // R6
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> (cnt == '0));
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
   localparam logic [1:0]  OP_RD = 2'd0, OP_WR = 2'd1;
   localparam logic [1:0]  A_CTRL = 2'd0, A_REL = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;
   localparam logic [31:0] CAL_WORD = 32'h400F_4240;
   localparam int          NVEC = 22;

   // {op, addr, wdata, expected rdata}
   localparam logic [67:0] VEC [NVEC] = '{
      {OP_RD, A_CTRL, 32'h0,         32'h0},
      {OP_RD, A_REL,  32'h0,         32'h0},
      {OP_RD, A_CUR,  32'h0,         32'h0},
      {OP_RD, A_CAL,  32'h0,         CAL_WORD},
      {OP_WR, A_REL,  32'hAB00_0005, 32'h0},
      {OP_RD, A_REL,  32'h0,         32'h5},
      {OP_WR, A_CUR,  32'hFFFF_FFFF, 32'h0},
      {OP_RD, A_CUR,  32'h0,         32'h0},
      {OP_WR, A_CTRL, 32'hFFFF_FFFF, 32'h0},
      {OP_RD, A_CTRL, 32'h0,         32'h7},
      {OP_RD, A_CUR,  32'h0,         32'h5},
      {OP_RD, A_CUR,  32'h0,         32'h4},
      {OP_RD, A_CUR,  32'h0,         32'h3},
      {OP_RD, A_CUR,  32'h0,         32'h2},
      {OP_RD, A_CUR,  32'h0,         32'h1},
      {OP_RD, A_CTRL, 32'h0,         32'h0001_0007},
      {OP_RD, A_CTRL, 32'h0,         32'h7},
      {OP_RD, A_CUR,  32'h0,         32'h4},
      {OP_WR, A_CTRL, 32'h0,         32'h0},
      {OP_RD, A_CUR,  32'h0,         32'h2},
      {OP_RD, A_CUR,  32'h0,         32'h2},
      {OP_RD, A_CTRL, 32'h0,         32'h0}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, ref_tick = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   tick_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ref_tick(ref_tick), .irq(irq)
   );

   always #2 clk = ~clk;

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle: drive at the falling edge, settle, caller samples
   task automatic drive(input logic s, input logic w, input logic [1:0] a,
                        input logic [31:0] d, input logic rt);
      @(negedge clk);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; ref_tick = rt;
      #1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      report();
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 irq after reset", {31'd0, irq}, 32'd0);

      // table walk: R1 R2 R3 R5 R6 R7 R8 R10 R11
      for (int i = 0; i < NVEC; i++) begin
         drive(1'b1, VEC[i][67:66] == OP_WR, VEC[i][65:64], VEC[i][63:32], 1'b0);
         if (VEC[i][67:66] == OP_RD)
            check($sformatf("R1/R2/R3/R5/R6/R7/R10/R11 vector %0d", i), bus_rdata, VEC[i][31:0]);
      end

      // R4: reference-strobe source, interrupt off
      drive(1'b1, 1'b1, A_REL,  32'h3, 1'b0);
      drive(1'b1, 1'b1, A_CUR,  32'h0, 1'b0);
      drive(1'b1, 1'b1, A_CTRL, 32'h1, 1'b0);
      for (int k = 0; k < 3; k++) begin
         drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
         check("R4 no strobe holds", bus_rdata, 32'h0);
      end
      drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b1);
      drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
      check("R4 strobe loads reload", bus_rdata, 32'h3);
      drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
      check("R4 idle strobe holds", bus_rdata, 32'h3);
      for (int k = 0; k < 3; k++) begin
         drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b1);
         check("R4 strobed count", bus_rdata, 32'(3 - k));
      end
      drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
      check("R4 reached zero", bus_rdata, 32'h0);
      check("R9 no irq when disabled", {31'd0, irq}, 32'd0);
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R6 flag set on wrap", bus_rdata, 32'h0001_0001);
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R7 flag cleared by read", bus_rdata, 32'h1);

      // R9: periodic interrupt, reload 2, core clock
      drive(1'b1, 1'b1, A_CTRL, 32'h0, 1'b0);
      drive(1'b1, 1'b1, A_REL,  32'h2, 1'b0);
      drive(1'b1, 1'b1, A_CUR,  32'h0, 1'b0);
      drive(1'b1, 1'b1, A_CTRL, 32'h7, 1'b0);
      for (int j = 0; j < 8; j++) begin
         drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
         check("R3 core-clock period", bus_rdata,
               (j == 0) ? 32'h0 : (j % 3 == 1) ? 32'h2 : (j % 3 == 2) ? 32'h1 : 32'h0);
         check("R9 irq single pulse", {31'd0, irq}, {31'd0, (j != 0 && j % 3 == 0)});
      end
      // R7: status read on the same edge as a wrap
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R7 sticky flag read", bus_rdata, 32'h0001_0007);
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R7 wrap beats read clear", bus_rdata, 32'h0001_0007);
      check("R9 irq on wrap", {31'd0, irq}, 32'd1);
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R7 read clears flag", bus_rdata, 32'h7);
      // R8: current write on the same edge as a wrap
      drive(1'b1, 1'b1, A_CUR, 32'h00AB_CDEF, 1'b0);
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R8 write beats wrap flag", bus_rdata, 32'h7);
      check("R8 no irq after clear", {31'd0, irq}, 32'd0);
      drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
      check("R8 reload after clear", bus_rdata, 32'h2);

      // R5: reload of zero stays at zero
      drive(1'b1, 1'b1, A_CTRL, 32'h0, 1'b0);
      drive(1'b1, 1'b1, A_REL,  32'h0, 1'b0);
      drive(1'b1, 1'b1, A_CUR,  32'h0, 1'b0);
      drive(1'b1, 1'b1, A_CTRL, 32'h7, 1'b0);
      for (int k = 0; k < 4; k++) begin
         drive(1'b1, 1'b0, A_CUR, 32'h0, 1'b0);
         check("R5 zero reload holds", bus_rdata, 32'h0);
         check("R5 zero reload no irq", {31'd0, irq}, 32'd0);
      end
      drive(1'b1, 1'b0, A_CTRL, 32'h0, 1'b0);
      check("R5 zero reload no flag", bus_rdata, 32'h7);

      // R11: calibration is read-only
      drive(1'b1, 1'b1, A_CAL, 32'h0, 1'b0);
      drive(1'b1, 1'b0, A_CAL, 32'h0, 1'b0);
      check("R11 calibration write ignored", bus_rdata, CAL_WORD);

      drive(1'b0, 1'b0, A_CTRL, 32'h0, 1'b0);
      report();
   end
endmodule